// File: doc/BRIEF.md
# Cache Bank Capacity Reconfiguration Controller

This controller decides, for a single cache bank, whether a stacked DRAM capacity extension sits above the SRAM bank or is switched out. There are only two capacity settings: SRAM alone, or SRAM together with the DRAM extension. The controller counts clock cycles in fixed reconfiguration windows. Within each window it tallies the bank's accesses and misses from per-access strobes. At the end of the window it compares a usage measure (the access count) and a miss-rate measure against threshold pairs supplied on configuration inputs. The capacity setting moves only when both measures point the same way.

The miss rate is never divided out. The miss count, scaled by 2^RATE_FRAC, is compared against the rate threshold multiplied by the access count. A rate threshold of 2^RATE_FRAC therefore stands for a miss rate of 1.0. Each change of setting raises a global core stall request for a fixed number of cycles. During that stall the access and miss strobes are disregarded.

The controller is a four-state machine:
- `ST_SRAM_ONLY`: extension off, no stall.
- `ST_GROW_STALL`: extension on, stalling.
- `ST_HYBRID`: extension on, no stall.
- `ST_SHRINK_STALL`: extension off, stalling.

It has these transitions:
- SRAM_ONLY→GROW_STALL, on a window end with the enable verdict.
- GROW_STALL→HYBRID, when the stall timer expires.
- HYBRID→SHRINK_STALL, on a window end with the disable verdict.
- SHRINK_STALL→SRAM_ONLY, when the stall timer expires.

Any other window end leaves the state unchanged.

Top module: `bank_reconfig_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `dram_en`, `stall_req` and `decision_valid` are 0. The first `decision_valid` appears after the INTERVAL_CYCLES-th rising edge following reset release.
- R2: `decision_valid` is a one-cycle pulse repeating every INTERVAL_CYCLES cycles.
- R3: With the extension on, a window end whose access count is below `use_lo_thr` and whose miss count × 2^RATE_FRAC is below `rate_lo_thr` × access count turns the extension off. The new `dram_en` appears in the same cycle as `decision_valid`.
- R4: With the extension off, a window end whose access count is above `use_hi_thr` and whose miss count × 2^RATE_FRAC is above `rate_hi_thr` × access count turns the extension on. The new `dram_en` appears in the same cycle as `decision_valid`.
- R5: If only one of the two measures crosses its threshold, the current setting is held. With zero accesses, the rate comparisons are both false and the setting is also held.
- R6: Every change of `dram_en` raises `stall_req` for exactly STALL_CYCLES consecutive cycles, starting in the cycle in which `dram_en` changes.
- R7: A window end that leaves the setting unchanged raises no stall.
- R8: Both tallies restart at each window end. A strobe sampled on the window-end edge counts toward the next window.
- R9: Strobes sampled while `stall_req` is high are not counted.
- R10: A `miss_stb` counts only when `access_stb` is high on the same edge. A miss strobe on its own is ignored.
- R11: `dram_en` changes only in a cycle in which `decision_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| access_stb | input | 1 | One bank access this cycle |
| miss_stb | input | 1 | That access missed |
| use_lo_thr | input | CNT_W | Usage threshold for switching off |
| use_hi_thr | input | CNT_W | Usage threshold for switching on |
| rate_lo_thr | input | RATE_W | Miss-rate threshold for switching off, in units of 2^-RATE_FRAC |
| rate_hi_thr | input | RATE_W | Miss-rate threshold for switching on, in units of 2^-RATE_FRAC |
| dram_en | output | 1 | DRAM extension enabled |
| stall_req | output | 1 | Global core stall request |
| decision_valid | output | 1 | One-cycle pulse per evaluated window |

## Verification
Two functions meet on the same edge.

The first is the window end that clears and reloads the tallies, together with a strobe arriving on that very edge. The bench drives strobe patterns that run through the last cycle of every window, so the carried-over count decides later verdicts.

The second is the stall, which starts at a window end, together with strobes that keep arriving during it. Patterns are chosen so that settings flip in both directions while strobes continue, and a per-cycle arithmetic model of the tallies judges every output cycle by cycle.

// File: rtl/recfg_pkg.sv
package recfg_pkg;

    typedef enum logic [1:0] {
        ST_SRAM_ONLY    = 2'd0,
        ST_GROW_STALL   = 2'd1,
        ST_HYBRID       = 2'd2,
        ST_SHRINK_STALL = 2'd3
    } cap_state_e;

    typedef struct packed {
        logic go_up;
        logic go_down;
    } verdict_t;

endpackage

// File: rtl/rc_interval_timer.sv
module rc_interval_timer #(
    parameter int INTERVAL = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (pos_q == LAST) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

    assign tick = (pos_q == LAST);

    // R2
    window_single_tick_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/rc_activity_cnt.sv
module rc_activity_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             hold,
    input  logic             acc_stb,
    input  logic             miss_stb,
    output logic [CNT_W-1:0] acc_cnt,
    output logic [CNT_W-1:0] miss_cnt
);
    logic take_acc;
    logic take_miss;

    assign take_acc  = acc_stb & ~hold;
    assign take_miss = take_acc & miss_stb;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_cnt  <= '0;
            miss_cnt <= '0;
        end else if (clear) begin
            acc_cnt  <= CNT_W'(take_acc);
            miss_cnt <= CNT_W'(take_miss);
        end else begin
            acc_cnt  <= acc_cnt + CNT_W'(take_acc);
            miss_cnt <= miss_cnt + CNT_W'(take_miss);
        end
    end

    // R9
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !clear) |=> ($stable(acc_cnt) && $stable(miss_cnt)));

    // R10
    miss_within_acc_chk: assert property (@(posedge clk) disable iff (rst)
        miss_cnt <= acc_cnt);

endmodule

// File: rtl/rc_decision.sv
module rc_decision
    import recfg_pkg::*;
#(
    parameter int CNT_W     = 24,
    parameter int RATE_FRAC = 8,
    parameter int RATE_W    = 9
) (
    input  logic [CNT_W-1:0]  acc_cnt,
    input  logic [CNT_W-1:0]  miss_cnt,
    input  logic [CNT_W-1:0]  use_lo,
    input  logic [CNT_W-1:0]  use_hi,
    input  logic [RATE_W-1:0] rate_lo,
    input  logic [RATE_W-1:0] rate_hi,
    output verdict_t          verdict
);
    localparam int EXT_W = (RATE_W > RATE_FRAC) ? RATE_W : RATE_FRAC;
    localparam int CMP_W = CNT_W + EXT_W;

    logic [CMP_W-1:0] miss_scaled;
    logic [CMP_W-1:0] lo_bound;
    logic [CMP_W-1:0] hi_bound;

    always_comb begin
        miss_scaled     = CMP_W'(miss_cnt) << RATE_FRAC;
        lo_bound        = CMP_W'(rate_lo) * CMP_W'(acc_cnt);
        hi_bound        = CMP_W'(rate_hi) * CMP_W'(acc_cnt);
        verdict.go_up   = (acc_cnt > use_hi) && (miss_scaled > hi_bound);
        verdict.go_down = (acc_cnt < use_lo) && (miss_scaled < lo_bound);
    end

endmodule

// File: rtl/rc_stall_timer.sv
module rc_stall_timer #(
    parameter int STALL = 100_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expire
);
    localparam int SW = $clog2(STALL + 1);

    logic [SW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (start) begin
            left_q <= SW'(STALL - 1);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign expire = (left_q == '0);

    // R6
    stall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        left_q < SW'(STALL));

endmodule

// File: rtl/bank_reconfig_ctrl.sv
module bank_reconfig_ctrl
    import recfg_pkg::*;
#(
    parameter int INTERVAL_CYCLES = 10_000_000,
    parameter int STALL_CYCLES    = 100_000,
    parameter int RATE_FRAC       = 8,
    parameter int RATE_W          = 9,
    parameter int CNT_W           = $clog2(INTERVAL_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              access_stb,
    input  logic              miss_stb,
    input  logic [CNT_W-1:0]  use_lo_thr,
    input  logic [CNT_W-1:0]  use_hi_thr,
    input  logic [RATE_W-1:0] rate_lo_thr,
    input  logic [RATE_W-1:0] rate_hi_thr,
    output logic              dram_en,
    output logic              stall_req,
    output logic              decision_valid
);
    cap_state_e       state_q;
    cap_state_e       state_d;
    logic             tick;
    logic             expire;
    logic             stall_start;
    verdict_t         verdict;
    logic [CNT_W-1:0] acc_cnt;
    logic [CNT_W-1:0] miss_cnt;

    initial begin
        params_ok_chk: assert (STALL_CYCLES >= 1 && STALL_CYCLES < INTERVAL_CYCLES);
    end

    rc_interval_timer #(.INTERVAL(INTERVAL_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rc_activity_cnt #(.CNT_W(CNT_W)) u_tally (
        .clk      (clk),
        .rst      (rst),
        .clear    (tick),
        .hold     (stall_req),
        .acc_stb  (access_stb),
        .miss_stb (miss_stb),
        .acc_cnt  (acc_cnt),
        .miss_cnt (miss_cnt)
    );

    rc_decision #(
        .CNT_W     (CNT_W),
        .RATE_FRAC (RATE_FRAC),
        .RATE_W    (RATE_W)
    ) u_judge (
        .acc_cnt  (acc_cnt),
        .miss_cnt (miss_cnt),
        .use_lo   (use_lo_thr),
        .use_hi   (use_hi_thr),
        .rate_lo  (rate_lo_thr),
        .rate_hi  (rate_hi_thr),
        .verdict  (verdict)
    );

    rc_stall_timer #(.STALL(STALL_CYCLES)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .start  (stall_start),
        .expire (expire)
    );

    // next-state logic
    always_comb begin
        state_d     = state_q;
        stall_start = 1'b0;
        unique case (state_q)
            ST_SRAM_ONLY: begin
                if (tick && verdict.go_up) begin
                    state_d     = ST_GROW_STALL;
                    stall_start = 1'b1;
                end
            end
            ST_HYBRID: begin
                if (tick && verdict.go_down) begin
                    state_d     = ST_SHRINK_STALL;
                    stall_start = 1'b1;
                end
            end
            ST_GROW_STALL: begin
                if (expire) state_d = ST_HYBRID;
            end
            ST_SHRINK_STALL: begin
                if (expire) state_d = ST_SRAM_ONLY;
            end
            default: state_d = ST_SRAM_ONLY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SRAM_ONLY;
        else     state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            dram_en        <= 1'b0;
            stall_req      <= 1'b0;
            decision_valid <= 1'b0;
        end else begin
            dram_en        <= (state_d == ST_GROW_STALL) || (state_d == ST_HYBRID);
            stall_req      <= (state_d == ST_GROW_STALL) || (state_d == ST_SHRINK_STALL);
            decision_valid <= tick;
        end
    end

    // R11
    en_moves_on_decision_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dram_en) |-> decision_valid);

    // R6
    stall_starts_with_change_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_req) |-> (decision_valid && !$stable(dram_en)));

    // R7
    quiet_when_held_chk: assert property (@(posedge clk) disable iff (rst)
        (decision_valid && $stable(dram_en)) |-> !stall_req);

endmodule

// File: tb/tb_bank_reconfig_ctrl.sv
module tb_bank_reconfig_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 32;
    localparam int STALL = 5;
    localparam int K     = 4;
    localparam int RW    = 5;
    localparam int CW    = $clog2(N + 1);
    localparam int ULO   = 8;
    localparam int UHI   = 20;
    localparam int RLO   = 4;
    localparam int RHI   = 8;
    localparam int NSCEN = 264;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          access_stb = 1'b0;
    logic          miss_stb = 1'b0;
    logic [CW-1:0] use_lo_thr = CW'(ULO);
    logic [CW-1:0] use_hi_thr = CW'(UHI);
    logic [RW-1:0] rate_lo_thr = RW'(RLO);
    logic [RW-1:0] rate_hi_thr = RW'(RHI);
    logic          dram_en;
    logic          stall_req;
    logic          decision_valid;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int pos = 0, acc = 0, miss = 0, left = 0, scen = 0;
    bit on = 0, dv = 0, chg = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_reconfig_ctrl #(
        .INTERVAL_CYCLES (N),
        .STALL_CYCLES    (STALL),
        .RATE_FRAC       (K),
        .RATE_W          (RW)
    ) dut (
        .clk            (clk),
        .rst            (rst),
        .access_stb     (access_stb),
        .miss_stb       (miss_stb),
        .use_lo_thr     (use_lo_thr),
        .use_hi_thr     (use_hi_thr),
        .rate_lo_thr    (rate_lo_thr),
        .rate_hi_thr    (rate_hi_thr),
        .dram_en        (dram_en),
        .stall_req      (stall_req),
        .decision_valid (decision_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // one clock: drive, advance the arithmetic model on the edge, compare
    task automatic step(input bit a_s, input bit m_s);
        bit stalling, take, mt, up, down;
        string en_tag;
        access_stb = a_s;
        miss_stb   = m_s;
        @(posedge clk);
        stalling = (left > 0);          // R9: strobes during stall are dropped
        take     = a_s && !stalling;
        mt       = take && m_s;         // R10: miss counts only with an access
        if (pos == N - 1) begin
            dv   = 1;
            pos  = 0;
            up   = !on && (acc > UHI) && (miss * (1 << K) > RHI * acc);
            down = on && (acc < ULO) && (miss * (1 << K) < RLO * acc);
            chg  = up || down;
            if (chg) begin
                on   = !on;
                left = STALL;
            end
            acc  = take ? 1 : 0;        // R8: boundary strobe opens next window
            miss = mt ? 1 : 0;
            scen++;
        end else begin
            dv  = 0;
            chg = 0;
            pos++;
            if (left > 0) left--;
            acc  += take ? 1 : 0;
            miss += mt ? 1 : 0;
        end
        @(negedge clk);
        if (dv && chg) en_tag = on ? "R4" : "R3";
        else if (dv)   en_tag = "R5";
        else           en_tag = "R11";
        chk(dram_en == on, en_tag, int'(dram_en), int'(on));
        chk(decision_valid == dv, "R2", int'(decision_valid), int'(dv));
        chk(stall_req == (left > 0), (dv && !chg) ? "R7" : "R6",
            int'(stall_req), int'(left > 0));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        int a, m, msel, mode;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_en == 0, "R1", int'(dram_en), 0);
        chk(stall_req == 0, "R1", int'(stall_req), 0);
        chk(decision_valid == 0, "R1", int'(decision_valid), 0);
        rst = 1'b0;
        // R1: first decision after N edges, checked by the model through R2 checks
        while (scen < NSCEN) begin
            a    = scen % 33;
            msel = (scen / 33) % 4;
            mode = (scen / 132) % 2;
            case (msel)
                0:       m = 0;
                1:       m = a / 4;
                2:       m = a / 2 + 1;
                default: m = a;
            endcase
            if (mode == 0)
                step(pos < a, pos < m);
            else
                step(pos < a, (pos >= a) && (pos < a + m)); // R10 orphan misses
        end
        repeat (N) step(1'b0, 1'b0);
        chk(1'b1, "R8", 0, 0);
        finish_up();
    end

endmodule